// File: doc/BRIEF.md
# Peripheral Module Clock Gate Controller

This block sits on a simple 32-bit register bus and decides which peripheral modules receive their functional clock. Software writes a two-bit mode into a per-module control register to ask for the clock to be switched on or off. The clock enable output follows the request on the next cycle. A separate two-bit idle-status field in the same register only reaches its final value after a settling window. Software therefore polls that field to learn when the module is really usable or really off. Some modules also carry an optional extra functional clock. That clock runs only while its bit is set and the module clock is enabled.

Beyond the module slots, the block holds four other registers. The first is a clock-domain control register: a software wakeup request in it raises three domain-clock-active flags one after another. The second holds one source select per timer. The third is a write-to-trigger warm reset request. The fourth is a peripheral reset hold bit that software clears to release a module. One further module cannot be gated at all, and its enable output is permanently on. The block drives enable and request outputs only. Gating cells, PLLs and the peripherals themselves live elsewhere.

Registers sit at word addresses. Module slot i is at 0x000 + 4*i. The domain register is at 0x100, and timer select t is at 0x200 + 4*t. The warm reset register is at 0x300 and the peripheral reset register at 0x304. Reads are combinational from the address.

Top module: `periph_clkgate_ctrl`

## Requirements
- R1: Writing mode value 2 into bits [1:0] of a module slot turns that slot's clock enable on, and mode value 0 turns it off. In both cases the change shows on the cycle after the write edge.
- R2: Idle status occupies bits [17:16] of a module slot and reads 3 (off) after reset. After an enable or disable request, it reads 1 (transition) from the second edge after the write, for SETTLE cycles. It then reads 0 (functional) after an enable, or 3 after a disable.
- R3: Mode values 1 and 3 are stored and read back in bits [1:0], but they leave the clock enable and the idle status as they were.
- R4: Bit 18 of a module slot is an optional clock enable. It is stored only for slots whose bit in OPT_MASK is set, and that output equals the stored bit ANDed with the slot clock enable. Other slots read 0 at bit 18 and drive 0.
- R5: The domain register holds a mode in bits [1:0], reading 3 after reset. After a write of 2, active flag j (j = 0..2, read at bit 4+j and driven on dom_clk_active[j]) sets WAKE+j cycles after the write edge.
- R6: The active flags all clear on the cycle after the domain mode is 3 and no module clock enable is on. While any module clock is on, set flags stay set.
- R7: Timer select t holds a 2-bit source code: 0 external pin, 1 main oscillator, 2 32 kHz clock. It reads 1 after reset. Codes 0 to 2 are taken on write, and code 3 is ignored.
- R8: A write to 0x300 with bit 1 set raises warm_rst_req for exactly one cycle, on the cycle after the write edge. Any other write to 0x300 has no effect, and the register reads 0.
- R9: Bit 1 of 0x304 reads 1 after reset and drives periph_rst_hold. Writing it to 0 releases the hold, and writing it to 1 applies the hold again.
- R10: fixed_clk_en is 1 at all times, including during reset.
- R11: Reads of any unmapped or unaligned address return 0. Writes there change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mod_clk_en | output | NUM_MOD | Functional clock enable per gated module |
| mod_opt_clk_en | output | NUM_MOD | Optional extra clock enable per module |
| fixed_clk_en | output | 1 | Enable of the ungated module, always 1 |
| dom_clk_active | output | 3 | Domain clock active flags |
| tmr_clk_src | output | 2*NUM_TMR | Source code per timer, timer t at bits [2t+1:2t] |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| periph_rst_hold | output | 1 | Peripheral module reset hold |

## Verification
The settling counter is the place where an internal fault hides longest. A wrong count or a wrong landing value appears only as an idle field that reads the wrong code too early or too late. So the bench reads the field on the exact edges around the transition, rather than after a long wait. A wrong stored mode or enable bit appears at mod_clk_en and in the readback on the cycle after the write. The domain counter is checked edge by edge against the staggered active flags. The reset-request and hold bits are visible at their ports one cycle after the bus write.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int REG_W      = 32;
    localparam int OPT_BIT    = 18;
    localparam int IDLE_LSB   = 16;
    localparam int ACT_LSB    = 4;
    localparam int NUM_ACT    = 3;
    localparam int RST_BIT    = 1;

    localparam int MOD_BASE   = 'h000;
    localparam int DOM_OFF    = 'h100;
    localparam int TMR_BASE   = 'h200;
    localparam int DEVRST_OFF = 'h300;
    localparam int PRST_OFF   = 'h304;

    typedef logic [1:0] fld2_t;

    localparam fld2_t MODE_OFF   = 2'd0;
    localparam fld2_t MODE_ON    = 2'd2;
    localparam fld2_t IDLE_FUNC  = 2'd0;
    localparam fld2_t IDLE_TRANS = 2'd1;
    localparam fld2_t IDLE_OFF   = 2'd3;
    localparam fld2_t DOM_SWWAKE = 2'd2;
    localparam fld2_t DOM_HWAUTO = 2'd3;
    localparam fld2_t SRC_OSC    = 2'd1;
    localparam fld2_t SRC_RSV    = 2'd3;

    typedef struct packed {
        logic warm;
        logic prst;
    } top_state_t;
endpackage

// File: rtl/pcg_gate_slot.sv
module pcg_gate_slot
    import pcg_pkg::*;
#(
    parameter int SETTLE  = 4,
    parameter bit HAS_OPT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  fld2_t            mode_in,
    input  logic             opt_in,
    output logic             clk_en,
    output logic             opt_en,
    output logic [REG_W-1:0] rdata
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        fld2_t            mode;
        logic             en;
        logic             opt;
        fld2_t            idle;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t s_d, s_q;
    fld2_t target;

    always_comb begin
        s_d    = s_q;
        target = s_q.en ? IDLE_FUNC : IDLE_OFF;
        if (s_q.idle != target) begin
            if (s_q.idle != IDLE_TRANS) begin
                s_d.idle = IDLE_TRANS;
                s_d.cnt  = CNT_W'(SETTLE - 1);
            end else if (s_q.cnt == '0) begin
                s_d.idle = target;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (wr_en) begin
            s_d.mode = mode_in;
            if (mode_in == MODE_ON) begin
                s_d.en = 1'b1;
            end else if (mode_in == MODE_OFF) begin
                s_d.en = 1'b0;
            end
            s_d.opt = HAS_OPT ? opt_in : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_OFF, en: 1'b0, opt: 1'b0, idle: IDLE_OFF, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_en = s_q.en;
    assign opt_en = s_q.opt & s_q.en;

    always_comb begin
        rdata = '0;
        rdata[1:0] = s_q.mode;
        rdata[IDLE_LSB +: 2] = s_q.idle;
        rdata[OPT_BIT] = s_q.opt;
    end

    assert_en_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_in == MODE_ON) |=> clk_en);
    assert_en_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_in == MODE_OFF) |=> !clk_en);
    assert_rsv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (mode_in == 2'd1 || mode_in == 2'd3)) |=> $stable(clk_en));
    assert_func_via_trans_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.idle == IDLE_FUNC && $past(s_q.idle) != IDLE_FUNC) |-> $past(s_q.idle) == IDLE_TRANS);
    assert_off_via_trans_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.idle == IDLE_OFF && $past(s_q.idle) != IDLE_OFF) |-> $past(s_q.idle) == IDLE_TRANS);
endmodule

// File: rtl/pcg_domain_wake.sv
module pcg_domain_wake
    import pcg_pkg::*;
#(
    parameter int WAKE = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  fld2_t              mode_in,
    input  logic               any_mod_en,
    output logic [NUM_ACT-1:0] active,
    output logic [REG_W-1:0]   rdata
);
    localparam int LIMIT = WAKE - 1 + NUM_ACT;
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        fld2_t              mode;
        logic [CNT_W-1:0]   cnt;
        logic [NUM_ACT-1:0] act;
    } dom_t;

    dom_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.mode == DOM_HWAUTO && !any_mod_en) begin
            s_d.act = '0;
            s_d.cnt = '0;
        end else if (s_q.mode == DOM_SWWAKE) begin
            if (s_q.cnt != CNT_W'(LIMIT)) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            for (int j = 0; j < NUM_ACT; j++) begin
                if (s_q.cnt == CNT_W'(WAKE - 1 + j)) begin
                    s_d.act[j] = 1'b1;
                end
            end
        end else begin
            s_d.cnt = '0;
        end
        if (wr_en) begin
            s_d.mode = mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: DOM_HWAUTO, cnt: '0, act: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.act;

    always_comb begin
        rdata = '0;
        rdata[1:0] = s_q.mode;
        rdata[ACT_LSB +: NUM_ACT] = s_q.act;
    end

    assert_act_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active[0]) |-> $past(s_q.mode) == DOM_SWWAKE);
    generate
        for (genvar j = 1; j < NUM_ACT; j++) begin : g_order
            assert_act_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
                active[j] |-> active[j-1]);
        end
    endgenerate
    assert_act_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == DOM_HWAUTO && !any_mod_en) |=> active == '0);
    assert_act_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active[0] && any_mod_en) |=> active[0]);
endmodule

// File: rtl/pcg_tmr_sel.sv
module pcg_tmr_sel
    import pcg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  fld2_t sel_in,
    output fld2_t sel
);
    fld2_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_en && sel_in != SRC_RSV) begin
            sel_d = sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SRC_OSC;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;

    assert_rsv_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_in == SRC_RSV) |=> $stable(sel));
    assert_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_in != SRC_RSV) |=> sel == $past(sel_in));
endmodule

// File: rtl/periph_clkgate_ctrl.sv
module periph_clkgate_ctrl
    import pcg_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                NUM_MOD  = 6,
    parameter int                NUM_TMR  = 3,
    parameter int                SETTLE   = 4,
    parameter int                WAKE     = 5,
    parameter logic [NUM_MOD-1:0] OPT_MASK = 6'b000011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic [NUM_MOD-1:0]   mod_clk_en,
    output logic [NUM_MOD-1:0]   mod_opt_clk_en,
    output logic                 fixed_clk_en,
    output logic [NUM_ACT-1:0]   dom_clk_active,
    output logic [2*NUM_TMR-1:0] tmr_clk_src,
    output logic                 warm_rst_req,
    output logic                 periph_rst_hold
);
    localparam logic [ADDR_W-1:0] A_DOM    = ADDR_W'(DOM_OFF);
    localparam logic [ADDR_W-1:0] A_DEVRST = ADDR_W'(DEVRST_OFF);
    localparam logic [ADDR_W-1:0] A_PRST   = ADDR_W'(PRST_OFF);

    logic [NUM_MOD-1:0] mod_hit;
    logic [NUM_TMR-1:0] tmr_hit;
    logic               dom_hit, devrst_hit, prst_hit, any_hit;
    logic [REG_W-1:0]   slot_rd [NUM_MOD];
    logic [REG_W-1:0]   dom_rd;
    fld2_t              tmr_val [NUM_TMR];
    logic               unused_wdata;

    assign unused_wdata = ^{bus_wdata[REG_W-1:OPT_BIT+1], bus_wdata[OPT_BIT-1:2]};

    assign dom_hit    = (bus_addr == A_DOM);
    assign devrst_hit = (bus_addr == A_DEVRST);
    assign prst_hit   = (bus_addr == A_PRST);

    generate
        for (genvar i = 0; i < NUM_MOD; i++) begin : g_slot
            assign mod_hit[i] = (bus_addr == ADDR_W'(MOD_BASE + 4 * i));
            pcg_gate_slot #(
                .SETTLE  (SETTLE),
                .HAS_OPT (OPT_MASK[i])
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && mod_hit[i]),
                .mode_in (bus_wdata[1:0]),
                .opt_in  (bus_wdata[OPT_BIT]),
                .clk_en  (mod_clk_en[i]),
                .opt_en  (mod_opt_clk_en[i]),
                .rdata   (slot_rd[i])
            );
        end
        for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
            assign tmr_hit[t] = (bus_addr == ADDR_W'(TMR_BASE + 4 * t));
            pcg_tmr_sel u_sel (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (bus_wr && tmr_hit[t]),
                .sel_in (bus_wdata[1:0]),
                .sel    (tmr_val[t])
            );
            assign tmr_clk_src[2*t +: 2] = tmr_val[t];
        end
    endgenerate

    pcg_domain_wake #(
        .WAKE (WAKE)
    ) u_dom (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr && dom_hit),
        .mode_in    (bus_wdata[1:0]),
        .any_mod_en (|mod_clk_en),
        .active     (dom_clk_active),
        .rdata      (dom_rd)
    );

    top_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.warm = bus_wr && devrst_hit && bus_wdata[RST_BIT];
        if (bus_wr && prst_hit) begin
            s_d.prst = bus_wdata[RST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{warm: 1'b0, prst: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign warm_rst_req    = s_q.warm;
    assign periph_rst_hold = s_q.prst;
    assign fixed_clk_en    = 1'b1;

    assign any_hit = (|mod_hit) | (|tmr_hit) | dom_hit | devrst_hit | prst_hit;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_MOD; i++) begin
            if (mod_hit[i]) bus_rdata = bus_rdata | slot_rd[i];
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            if (tmr_hit[t]) bus_rdata[1:0] = bus_rdata[1:0] | tmr_val[t];
        end
        if (dom_hit)  bus_rdata = bus_rdata | dom_rd;
        if (prst_hit) bus_rdata[RST_BIT] = s_q.prst;
    end

    assert_warm_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_req && !(bus_wr && devrst_hit)) |=> !warm_rst_req);
    assert_warm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_rst_req) |-> ($past(bus_wr) && $past(bus_addr) == A_DEVRST));
    assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst_hold) |-> ($past(bus_wr) && $past(bus_addr) == A_PRST));
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> bus_rdata == '0);
    assert_fixed_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_clk_en);
endmodule

// File: tb/periph_clkgate_ctrl_test.sv
module periph_clkgate_ctrl_test;
    localparam int NM = 6, NT = 3, SET = 4, WK = 5;
    localparam logic [NM-1:0] OMASK = 6'b000011;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NM-1:0] mod_clk_en, mod_opt_clk_en;
    logic        fixed_clk_en, warm_rst_req, periph_rst_hold;
    logic [2:0]  dom_clk_active;
    logic [2*NT-1:0] tmr_clk_src;

    int n_chk = 0, n_err = 0;
    logic [NM-1:0] exp_en = '0, exp_opt = '0;
    logic [31:0] r;

    always #2.5 clk = ~clk;

    periph_clkgate_ctrl #(.ADDR_W(12), .NUM_MOD(NM), .NUM_TMR(NT), .SETTLE(SET),
                          .WAKE(WK), .OPT_MASK(OMASK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_clk_en(mod_clk_en),
        .mod_opt_clk_en(mod_opt_clk_en), .fixed_clk_en(fixed_clk_en),
        .dom_clk_active(dom_clk_active), .tmr_clk_src(tmr_clk_src),
        .warm_rst_req(warm_rst_req), .periph_rst_hold(periph_rst_hold));

    function automatic logic [1:0] idle_of(input logic [31:0] v);
        return v[17:16];
    endfunction
    function automatic logic [1:0] settled_idle(input logic en);
        return en ? 2'd0 : 2'd3;
    endfunction
    function automatic logic [11:0] mod_addr(input int m);
        return 12'(4 * m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        check("R10 fixed during reset", 32'(fixed_clk_en), 32'd1);
        rst_n = 1'b1;
        tick(1);
        // reset state
        check("R1 reset enables", 32'(mod_clk_en), 32'd0);
        rd(mod_addr(0), r); check("R2 reset idle", 32'(idle_of(r)), 32'd3);
        rd(12'h100, r);     check("R5 reset domain", r, 32'h3);
        check("R7 reset timer src", 32'(tmr_clk_src), 32'b010101);
        check("R9 reset hold", 32'(periph_rst_hold), 32'd1);
        check("R8 reset warm", 32'(warm_rst_req), 32'd0);
        check("R10 fixed on", 32'(fixed_clk_en), 32'd1);
        rd(12'h0F0, r);     check("R11 unmapped read", r, 32'd0);

        // R1 / R2 enable handshake timing on slot 2
        wr(mod_addr(2), 32'd2);
        check("R1 enable next cycle", 32'(mod_clk_en[2]), 32'd1);
        rd(mod_addr(2), r); check("R2 idle before start", 32'(idle_of(r)), 32'd3);
        tick(1); rd(mod_addr(2), r); check("R2 idle transition", 32'(idle_of(r)), 32'd1);
        tick(SET - 1); rd(mod_addr(2), r); check("R2 idle still transition", 32'(idle_of(r)), 32'd1);
        tick(1); rd(mod_addr(2), r); check("R2 idle functional", 32'(idle_of(r)), 32'd0);
        // disable
        wr(mod_addr(2), 32'd0);
        check("R1 disable next cycle", 32'(mod_clk_en[2]), 32'd0);
        tick(1); rd(mod_addr(2), r); check("R2 idle leaving", 32'(idle_of(r)), 32'd1);
        tick(SET); rd(mod_addr(2), r); check("R2 idle off", 32'(idle_of(r)), 32'd3);

        // R3 reserved modes
        wr(mod_addr(3), 32'd2); tick(SET + 2);
        wr(mod_addr(3), 32'd1);
        check("R3 mode1 keeps enable", 32'(mod_clk_en[3]), 32'd1);
        rd(mod_addr(3), r); check("R3 mode1 stored", 32'(r[1:0]), 32'd1);
        tick(SET + 2); rd(mod_addr(3), r); check("R3 mode1 idle kept", 32'(idle_of(r)), 32'd0);
        wr(mod_addr(4), 32'd3);
        check("R3 mode3 keeps off", 32'(mod_clk_en[4]), 32'd0);
        tick(SET + 2); rd(mod_addr(4), r); check("R3 mode3 idle kept", r, 32'h0003_0003);
        wr(mod_addr(3), 32'd0); wr(mod_addr(4), 32'd0);

        // R4 optional clock
        wr(mod_addr(0), 32'h0004_0002);
        check("R4 opt on", 32'(mod_opt_clk_en[0]), 32'd1);
        rd(mod_addr(0), r); check("R4 opt readback", 32'(r[18]), 32'd1);
        wr(mod_addr(5), 32'h0004_0002);
        check("R4 no opt slot", 32'(mod_opt_clk_en[5]), 32'd0);
        rd(mod_addr(5), r); check("R4 no opt readback", 32'(r[18]), 32'd0);
        wr(mod_addr(0), 32'h0004_0000);
        check("R4 opt gated by enable", 32'(mod_opt_clk_en[0]), 32'd0);
        wr(mod_addr(5), 32'd0); wr(mod_addr(0), 32'd0);
        tick(1);
        check("R6 cleared before wake", 32'(dom_clk_active), 32'd0);

        // R5 wakeup stagger
        wr(12'h100, 32'd2);
        tick(WK - 1); check("R5 none yet", 32'(dom_clk_active), 32'd0);
        tick(1); check("R5 first flag", 32'(dom_clk_active), 32'b001);
        tick(1); check("R5 second flag", 32'(dom_clk_active), 32'b011);
        tick(1); check("R5 third flag", 32'(dom_clk_active), 32'b111);
        rd(12'h100, r); check("R5 readback", r, 32'h72);

        // R6 clear condition
        wr(mod_addr(1), 32'd2);
        wr(12'h100, 32'd3);
        tick(2); check("R6 kept while module on", 32'(dom_clk_active), 32'b111);
        wr(mod_addr(1), 32'd0);
        check("R6 not yet cleared", 32'(dom_clk_active), 32'b111);
        tick(1); check("R6 cleared", 32'(dom_clk_active), 32'd0);

        // R7 timer select
        wr(12'h204, 32'd0); check("R7 take ext", 32'(tmr_clk_src[3:2]), 32'd0);
        wr(12'h204, 32'd2); check("R7 take 32k", 32'(tmr_clk_src[3:2]), 32'd2);
        wr(12'h204, 32'd3); check("R7 reserved ignored", 32'(tmr_clk_src[3:2]), 32'd2);
        rd(12'h204, r); check("R7 readback", r, 32'd2);
        check("R7 others kept", 32'({tmr_clk_src[5:4], tmr_clk_src[1:0]}), 32'b0101);

        // R8 warm reset
        wr(12'h300, 32'd2);
        check("R8 warm pulse", 32'(warm_rst_req), 32'd1);
        tick(1); check("R8 warm single", 32'(warm_rst_req), 32'd0);
        rd(12'h300, r); check("R8 reads zero", r, 32'd0);
        wr(12'h300, 32'd1); check("R8 bit0 no effect", 32'(warm_rst_req), 32'd0);

        // R9 peripheral hold
        wr(12'h304, 32'd0); check("R9 release", 32'(periph_rst_hold), 32'd0);
        rd(12'h304, r); check("R9 readback", r, 32'd0);
        wr(12'h304, 32'd2); check("R9 hold again", 32'(periph_rst_hold), 32'd1);

        // R11 unmapped writes
        wr(12'h0FC, 32'hFFFF_FFFF); wr(12'h001, 32'h2); wr(12'h101, 32'h2);
        check("R11 no enable", 32'(mod_clk_en), 32'd0);
        check("R11 no source change", 32'(tmr_clk_src), 32'b011001);
        rd(12'h001, r); check("R11 unaligned read", r, 32'd0);
        rd(12'h0FC, r); check("R11 unmapped read", r, 32'd0);
        tick(WK + 4); check("R11 no wake", 32'(dom_clk_active), 32'd0);

        // random mode writes
        void'($urandom(32'h5EED));
        for (int it = 0; it < 60; it++) begin
            int m, v, o;
            m = $urandom_range(0, NM - 1);
            v = $urandom_range(0, 3);
            o = $urandom_range(0, 1);
            wr(mod_addr(m), 32'(v) | (32'(o) << 18));
            if (v == 2) exp_en[m] = 1'b1;
            if (v == 0) exp_en[m] = 1'b0;
            exp_opt[m] = OMASK[m] & 1'(o);
            check("R1 R3 random enables", 32'(mod_clk_en), 32'(exp_en));
            check("R4 random opt", 32'(mod_opt_clk_en), 32'(exp_opt & exp_en));
            rd(mod_addr(m), r);
            check("R3 random mode readback", 32'(r[1:0]), 32'(v));
            tick(SET + 2);
            rd(mod_addr(m), r);
            check("R2 random settled idle", 32'(idle_of(r)), 32'(settled_idle(exp_en[m])));
        end
        finish_run();
    end
endmodule